// File: doc/BRIEF.md
# Resolver Fault Monitor and Latch

This block gathers fault conditions from a resolver-to-digital front end and reports them on two active-low pins, `dosN` and `lotN`. The pins carry a two-bit priority code. Three fault sources arrive as synchronous flags: loss of signal, signal degradation and tracking loss. A fourth is input clipping, which the block qualifies per channel with a duration counter. A fifth is a parity failure in the block's own configuration registers. A phase-lock error drives the tracking code only while it is present. Every other fault is sticky.

A host reaches the block through a simple strobe interface while `cfgMode` is high. It writes the configuration registers, one 8-bit word per address. It also reads an 8-bit fault register on `faultData`, which is cleared on the clock edge that ends a read strobe. Register 0 is the control register. Its bit 5 selects the narrow phase-lock range. When that bit is cleared, the lock range is unlimited and no phase error is reported.

Top module: `resolver_fault_monitor`

## Requirements
- R1: The pin code `{dosN,lotN}` is chosen by priority. A latched clip, loss-of-signal or parity fault gives 2'b00. Otherwise a latched degradation gives 2'b01. Otherwise a latched tracking loss or a live phase error gives 2'b10. With no fault, the code is 2'b11.
- R2: A clip channel faults only when its flag in `clipIn` is high on more than `CLK_MHZ*CLIP_US` consecutive clock edges. Exactly that many edges produce no fault.
- R3: A qualified clip on any channel latches the pins to 2'b00 and sets fault register bit 7.
- R4: Each configuration word must contain an odd number of ones across all 8 bits. The check runs continuously on the stored words. A word with even parity latches the pins to 2'b00 and sets bit 0.
- R5: A phase error (`phaseErrIn`) gives code 2'b10 one clock after it is sampled, and the code returns to 2'b11 one clock after the error goes away. It also sets bit 1, and bit 1 holds until it is read.
- R6: When bit 5 of configuration register 0 is 0, `phaseErrIn` affects neither the pins nor bit 1.
- R7: A sampled loss of signal sets bit 6, a degradation sets bit 5 and a tracking loss sets bit 4. These bits, together with bits 7, 1 and 0, stay set after their cause goes away. Bits 3 and 2 read 0.
- R8: `faultData` shows the fault register. A `faultRdEn` strobe with `cfgMode` high clears the register on the edge that ends it. A condition still active on that edge sets its bit again at once. A strobe with `cfgMode` low has no effect.
- R9: `cfgWrEn` stores `cfgWrData` at `cfgAddr` only while `cfgMode` is high. At other times the write is ignored.
- R10: Active-low synchronous reset clears the fault register and the clip counters. It loads register 0 with 8'h20 and the other registers with 8'h80, so the pins read 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| losIn | input | 1 | Loss-of-signal condition |
| degIn | input | 1 | Signal-degradation condition |
| trkIn | input | 1 | Tracking-loss condition |
| clipIn | input | NUM_CH | Per-channel out-of-range comparator flags |
| phaseErrIn | input | 1 | Phase-lock error condition |
| cfgMode | input | 1 | Host configuration mode |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | AW | Configuration register address |
| cfgWrData | input | 8 | Configuration write word, parity in bit 7 |
| faultRdEn | input | 1 | Fault register read strobe |
| faultData | output | 8 | Fault register contents |
| dosN | output | 1 | Fault code pin, upper bit |
| lotN | output | 1 | Fault code pin, lower bit |

## Verification
Some rules can be checked on every cycle, and the assertions cover these. They check that a set fault bit survives any cycle without a clear and that a clear with no active condition empties the register. They check that stored bad parity always reaches bit 0, that a clip hit needs the flag to have been high in the previous cycle, that a cleared range bit holds the phase output low, and that the severe code appears whenever a severe bit is latched. The bench's scenarios cover what those rules cannot show. These are the exact boundary of the clip counter, priority when several faults are present together, a condition set again during the clearing read, ignored reads and writes outside configuration mode, and the default register values after reset.

// File: rtl/rfm_pkg.sv
package rfm_pkg;

  // fault register bit positions
  localparam int BIT_CLIP   = 7;
  localparam int BIT_LOS    = 6;
  localparam int BIT_DEG    = 5;
  localparam int BIT_TRK    = 4;
  localparam int BIT_PHASE  = 1;
  localparam int BIT_PARITY = 0;

  // control-register bit selecting the narrow phase-lock range
  localparam int NARROW_BIT = 5;

  // host strobes, qualified by configuration mode
  typedef struct packed {
    logic clear;
    logic write;
  } strobe_t;

  // latched conditions that steer the pin code
  typedef struct packed {
    logic clip;
    logic los;
    logic deg;
    logic trk;
    logic parity;
  } latch_flags_t;

  // {dosN, lotN}
  typedef enum logic [1:0] {
    CODE_SEVERE  = 2'b00,
    CODE_DEGRADE = 2'b01,
    CODE_TRACK   = 2'b10,
    CODE_IDLE    = 2'b11
  } pin_code_e;

endpackage

// File: rtl/rfm_datapath.sv
module rfm_datapath
  import rfm_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int CLIP_CYCLES = 800,
  parameter int NUM_CFG     = 4,
  parameter int AW          = 2,
  parameter int CTRL_IDX    = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              losIn,
  input  logic              degIn,
  input  logic              trkIn,
  input  logic              phaseIn,
  input  logic [NUM_CH-1:0] clipIn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        faultReg,
  output latch_flags_t      flags,
  output logic              phaseLive
);

  localparam int          CW       = $clog2(CLIP_CYCLES + 1);
  localparam logic [CW-1:0] CLIP_MAX = CW'(CLIP_CYCLES);
  localparam logic [7:0]  CTRL_DEF = 8'h20;
  localparam logic [7:0]  DATA_DEF = 8'h80;

  logic [NUM_CH-1:0]  clipHit;
  logic [NUM_CFG-1:0] parityBad;
  logic [7:0]         cfgRegs [NUM_CFG];
  logic               phaseEff;
  logic [7:0]         cond;

  // per-channel duration qualifiers
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_clip
    logic [CW-1:0] holdCnt;
    always_ff @(posedge clk) begin
      if (!rstN)                 holdCnt <= '0;
      else if (!clipIn[ch])      holdCnt <= '0;
      else if (holdCnt != CLIP_MAX) holdCnt <= holdCnt + 1'b1;
    end
    assign clipHit[ch] = clipIn[ch] && (holdCnt == CLIP_MAX);

    // R2
    clip_needs_history_chk: assert property (@(posedge clk) disable iff (!rstN)
      clipHit[ch] |-> $past(clipIn[ch]));
  end

  // configuration words with continuous parity check
  for (genvar r = 0; r < NUM_CFG; r++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rstN)
        cfgRegs[r] <= (r == CTRL_IDX) ? CTRL_DEF : DATA_DEF;
      else if (stb.write && wrAddr == AW'(r))
        cfgRegs[r] <= wrData;
    end
    assign parityBad[r] = ~^cfgRegs[r];
  end

  assign phaseEff = phaseIn && cfgRegs[CTRL_IDX][NARROW_BIT];

  always_comb begin
    cond             = '0;
    cond[BIT_CLIP]   = |clipHit;
    cond[BIT_LOS]    = losIn;
    cond[BIT_DEG]    = degIn;
    cond[BIT_TRK]    = trkIn;
    cond[BIT_PHASE]  = phaseEff;
    cond[BIT_PARITY] = |parityBad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultReg  <= '0;
      phaseLive <= 1'b0;
    end else begin
      faultReg  <= (stb.clear ? 8'h00 : faultReg) | cond;
      phaseLive <= phaseEff;
    end
  end

  assign flags = '{clip:   faultReg[BIT_CLIP],
                   los:    faultReg[BIT_LOS],
                   deg:    faultReg[BIT_DEG],
                   trk:    faultReg[BIT_TRK],
                   parity: faultReg[BIT_PARITY]};

  // R7
  sticky_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.clear |=> ((faultReg & $past(faultReg)) == $past(faultReg)));

  // R8
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clear && cond == 8'h00) |=> (faultReg == 8'h00));

  // R4
  parity_latched_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|parityBad) |=> faultReg[BIT_PARITY]);

  // R6
  wide_range_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRegs[CTRL_IDX][NARROW_BIT] |=> !phaseLive);

endmodule

// File: rtl/rfm_control.sv
module rfm_control
  import rfm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgMode,
  input  logic         faultRdEn,
  input  logic         cfgWrEn,
  input  latch_flags_t flags,
  input  logic         phaseLive,
  output strobe_t      stb,
  output logic         dosN,
  output logic         lotN
);

  pin_code_e code;

  always_comb begin
    stb.clear = cfgMode && faultRdEn;
    stb.write = cfgMode && cfgWrEn;
    if (flags.clip || flags.los || flags.parity) code = CODE_SEVERE;
    else if (flags.deg)                          code = CODE_DEGRADE;
    else if (flags.trk || phaseLive)             code = CODE_TRACK;
    else                                         code = CODE_IDLE;
  end

  assign {dosN, lotN} = code;

  // R1
  severe_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flags.los || flags.clip || flags.parity) |-> (!dosN && !lotN));

  // R1
  idle_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flags == '0 && !phaseLive) |-> (dosN && lotN));

endmodule

// File: rtl/resolver_fault_monitor.sv
module resolver_fault_monitor
  import rfm_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CLK_MHZ  = 200,
  parameter int CLIP_US  = 4,
  parameter int NUM_CFG  = 4,
  localparam int AW      = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              losIn,
  input  logic              degIn,
  input  logic              trkIn,
  input  logic [NUM_CH-1:0] clipIn,
  input  logic              phaseErrIn,
  input  logic              cfgMode,
  input  logic              cfgWrEn,
  input  logic [AW-1:0]     cfgAddr,
  input  logic [7:0]        cfgWrData,
  input  logic              faultRdEn,
  output logic [7:0]        faultData,
  output logic              dosN,
  output logic              lotN
);

  localparam int CLIP_CYCLES = CLK_MHZ * CLIP_US;

  strobe_t      stb;
  latch_flags_t flags;
  logic         phaseLive;

  rfm_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgMode   (cfgMode),
    .faultRdEn (faultRdEn),
    .cfgWrEn   (cfgWrEn),
    .flags     (flags),
    .phaseLive (phaseLive),
    .stb       (stb),
    .dosN      (dosN),
    .lotN      (lotN)
  );

  rfm_datapath #(
    .NUM_CH      (NUM_CH),
    .CLIP_CYCLES (CLIP_CYCLES),
    .NUM_CFG     (NUM_CFG),
    .AW          (AW),
    .CTRL_IDX    (0)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .losIn     (losIn),
    .degIn     (degIn),
    .trkIn     (trkIn),
    .phaseIn   (phaseErrIn),
    .clipIn    (clipIn),
    .wrAddr    (cfgAddr),
    .wrData    (cfgWrData),
    .faultReg  (faultData),
    .flags     (flags),
    .phaseLive (phaseLive)
  );

endmodule

// File: tb/resolver_fault_monitor_test.sv
module resolver_fault_monitor_test;

  localparam int CLIP = 200 * 4;

  typedef struct {
    logic [1:0] pins;
    logic [7:0] data;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       losIn = 1'b0, degIn = 1'b0, trkIn = 1'b0, phaseErrIn = 1'b0;
  logic [3:0] clipIn = '0;
  logic       cfgMode = 1'b0, cfgWrEn = 1'b0, faultRdEn = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [7:0] cfgWrData = '0;
  logic [7:0] faultData;
  logic       dosN, lotN;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  resolver_fault_monitor uut (
    .clk(clk), .rstN(rstN), .losIn(losIn), .degIn(degIn), .trkIn(trkIn),
    .clipIn(clipIn), .phaseErrIn(phaseErrIn), .cfgMode(cfgMode),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .faultRdEn(faultRdEn), .faultData(faultData), .dosN(dosN), .lotN(lotN)
  );

  // monitor: pops expectations and compares away from the active edge
  always @(negedge clk) begin
    exp_t it;
    while (expQ.size() > 0) begin
      it = expQ.pop_front();
      checks++;
      if ({dosN, lotN} !== it.pins || faultData !== it.data) begin
        errors++;
        $display("FAIL %s: pins=%b data=%h expected pins=%b data=%h",
                 it.tag, {dosN, lotN}, faultData, it.pins, it.data);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expectOut(input logic [1:0] pins, input logic [7:0] data, input string tag);
    expQ.push_back('{pins, data, tag});
  endtask

  task automatic hostRead(input logic [1:0] pins, input logic [7:0] data, input string tag);
    cfgMode = 1'b1; faultRdEn = 1'b1;
    expectOut(pins, data, tag);
    tick(1);
    faultRdEn = 1'b0; cfgMode = 1'b0;
  endtask

  task automatic hostWrite(input logic [1:0] addr, input logic [7:0] data);
    cfgMode = 1'b1; cfgWrEn = 1'b1; cfgAddr = addr; cfgWrData = data;
    tick(1);
    cfgWrEn = 1'b0; cfgMode = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    expectOut(2'b11, 8'h00, "R10 reset state");

    // loss of signal: highest priority, sticky
    losIn = 1'b1; tick(1);
    expectOut(2'b00, 8'h40, "R1 loss of signal code");
    losIn = 1'b0; tick(5);
    expectOut(2'b00, 8'h40, "R7 loss of signal held");
    faultRdEn = 1'b1; tick(1); faultRdEn = 1'b0; tick(1);
    expectOut(2'b00, 8'h40, "R8 read outside config mode ignored");
    hostRead(2'b00, 8'h40, "R8 read returns latched bits");
    expectOut(2'b11, 8'h00, "R8 cleared after read");

    // degradation and priority among simultaneous faults
    degIn = 1'b1; tick(1);
    expectOut(2'b01, 8'h20, "R1 degradation code");
    trkIn = 1'b1; tick(1);
    expectOut(2'b01, 8'h30, "R1 degradation over tracking");
    losIn = 1'b1; tick(1);
    expectOut(2'b00, 8'h70, "R1 loss of signal over degradation");
    losIn = 1'b0; degIn = 1'b0; trkIn = 1'b0; tick(1);
    hostRead(2'b00, 8'h70, "R7 all three held");
    expectOut(2'b11, 8'h00, "R8 cleared");

    // tracking loss, active during the clearing read
    trkIn = 1'b1; tick(1);
    expectOut(2'b10, 8'h10, "R1 tracking code");
    hostRead(2'b10, 8'h10, "R8 read with condition active");
    expectOut(2'b10, 8'h10, "R8 active condition sets bit again");
    trkIn = 1'b0; tick(1);
    hostRead(2'b10, 8'h10, "R7 tracking held");
    expectOut(2'b11, 8'h00, "R8 cleared");

    // phase error: live on pin, sticky in register
    phaseErrIn = 1'b1; tick(1);
    expectOut(2'b10, 8'h02, "R5 phase error code");
    phaseErrIn = 1'b0; tick(1);
    expectOut(2'b11, 8'h02, "R5 pin not latched, bit held");
    hostRead(2'b11, 8'h02, "R5 read");
    expectOut(2'b11, 8'h00, "R5 cleared");

    // wide lock range: control word 0x80 (bit 5 clear, odd parity)
    hostWrite(2'd0, 8'h80);
    phaseErrIn = 1'b1; tick(2);
    expectOut(2'b11, 8'h00, "R6 phase error ignored in wide range");
    phaseErrIn = 1'b0;
    hostWrite(2'd0, 8'h20); tick(1);
    expectOut(2'b11, 8'h00, "R4 valid control word no parity fault");
    phaseErrIn = 1'b1; tick(1);
    expectOut(2'b10, 8'h02, "R6 narrow range restored");
    phaseErrIn = 1'b0; tick(1);
    hostRead(2'b11, 8'h02, "R5 read");
    expectOut(2'b11, 8'h00, "R5 cleared");

    // write outside configuration mode
    cfgWrEn = 1'b1; cfgAddr = 2'd2; cfgWrData = 8'h00; tick(1); cfgWrEn = 1'b0;
    tick(2);
    expectOut(2'b11, 8'h00, "R9 write outside config mode ignored");

    // parity corruption
    hostWrite(2'd2, 8'h00); tick(1);
    expectOut(2'b00, 8'h01, "R4 even parity word faults");
    hostRead(2'b00, 8'h01, "R4 read");
    expectOut(2'b00, 8'h01, "R4 still bad after read");
    hostWrite(2'd2, 8'h83);
    hostRead(2'b00, 8'h01, "R4 read after repair");
    expectOut(2'b11, 8'h00, "R4 cleared after repair");

    // clip boundary: exactly CLIP edges gives no fault
    clipIn = 4'b0010; tick(CLIP);
    clipIn = 4'b0000; tick(2);
    expectOut(2'b11, 8'h00, "R2 clip of exactly limit not flagged");
    clipIn = 4'b0100; tick(CLIP);
    expectOut(2'b11, 8'h00, "R2 clip not yet flagged");
    tick(1);
    expectOut(2'b00, 8'h80, "R3 clip flagged after limit");
    clipIn = 4'b0000; tick(1);
    expectOut(2'b00, 8'h80, "R7 clip held");
    hostRead(2'b00, 8'h80, "R3 read");
    expectOut(2'b11, 8'h00, "R8 cleared");

    tick(2);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule